// File: doc/BRIEF.md
# Cartridge ROM/RAM Half-Bank Switcher

This block decodes processor accesses to an 8 KB cartridge window at 0x6000 to 0x7FFF. The lower 4 KB of the window shows one 4 KB page of a larger ROM. The upper 4 KB shows one 4 KB page of a larger RAM, which the processor can both read and write. Each half has its own page register, and the two registers change independently of each other.

A page change is a processor write to a trigger range in the lower half. A write anywhere in 0x6000 to 0x60FF selects a ROM page from the write's address bits. A write anywhere in 0x6800 to 0x68FF selects a RAM page from the write's data byte. Writes into the RAM half only store data and never move a page. The block forms the extended ROM and RAM addresses and the chip enables. The memories themselves sit outside the block.

Top module: `cart_halfbank_switch`

## Requirements
- R1: When `cs`=1 and `we`=0 and the address is 0x6000 to 0x6FFF, `rom_ce`=1. `rom_addr` always equals {ROM page, addr[11:0]}. `rom_ce` is 0 on every write.
- R2: When `cs`=1 and the address is 0x7000 to 0x7FFF, `ram_ce`=1 for both reads and writes, and `ram_we` equals `we`. `ram_addr` always equals {RAM page, addr[11:0]}. Outside this range `ram_ce` and `ram_we` are 0.
- R3: A write with `cs`=1 to 0x6000 to 0x60FF loads the ROM page from addr[ROM_BANK_W:1], with addr[0] ignored. The new page shows from the next cycle on.
- R4: A write with `cs`=1 to 0x6800 to 0x68FF loads the RAM page from wdata[RAM_BANK_W-1:0], with addr[7:0] ignored. The new page shows from the next cycle on.
- R5: A ROM trigger write leaves the RAM page unchanged, and a RAM trigger write leaves the ROM page unchanged.
- R6: A write anywhere in 0x7000 to 0x7FFF changes neither page.
- R7: Writes to 0x6100 to 0x67FF, to 0x6900 to 0x6FFF, and outside 0x6000 to 0x7FFF change neither page.
- R8: With `cs`=0, all chip enables are 0 and no write changes a page.
- R9: A synchronous reset (`rst`=1 at a clock edge) sets both pages to 0. The bench's RAM model is cleared with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Cartridge select, active high |
| we | input | 1 | Write strobe for the current access, active high |
| addr | input | 16 | Processor byte address |
| wdata | input | 8 | Processor write data |
| rom_addr | output | ROM_BANK_W+12 | Extended ROM address |
| rom_ce | output | 1 | ROM chip enable |
| ram_addr | output | RAM_BANK_W+12 | Extended RAM address |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |

## Verification
The directed part aims writes at each region. ROM triggers use odd addresses, so a design that uses addr[0] gives a different page. RAM triggers use nonzero low address bits, so a design that reads the page from the address instead of the data is caught. Writes into the RAM half, into the gaps between trigger ranges, outside the window, and with `cs` low show whether any decode is too wide. Alternating ROM and RAM triggers separate the two registers. A pseudo-random stream then mixes all regions. A RAM model keyed by the design's address is compared with one keyed by the expected address, so a RAM write that lands in the wrong place shows up on a later read.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int OFFSET_W   = 12;
    localparam int CPU_ADDR_W = 16;

    typedef enum logic [1:0] {
        HALF_NONE = 2'd0,
        HALF_ROM  = 2'd1,
        HALF_RAM  = 2'd2
    } half_e;

    typedef struct packed {
        half_e half;
        logic  rom_trig;
        logic  ram_trig;
    } decode_t;

    typedef struct packed {
        logic rom_ce;
        logic ram_ce;
        logic ram_we;
        logic rom_load;
        logic ram_load;
    } access_t;

    function automatic decode_t classify(input logic [CPU_ADDR_W-1:0] a);
        decode_t d;
        unique case (a[15:12])
            4'h6:    d.half = HALF_ROM;
            4'h7:    d.half = HALF_RAM;
            default: d.half = HALF_NONE;
        endcase
        d.rom_trig = (a[15:8] == 8'h60);
        d.ram_trig = (a[15:8] == 8'h68);
        return d;
    endfunction

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_bank_pkg::*;
(
    input  logic                  cs,
    input  logic                  we,
    input  logic [CPU_ADDR_W-1:0] addr,
    output access_t               acc
);
    decode_t dec;

    always_comb begin
        dec          = classify(addr);
        acc.rom_ce   = cs && !we && (dec.half == HALF_ROM);
        acc.ram_ce   = cs && (dec.half == HALF_RAM);
        acc.ram_we   = cs && we && (dec.half == HALF_RAM);
        acc.rom_load = cs && we && dec.rom_trig;
        acc.ram_load = cs && we && dec.ram_trig;
    end
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/cart_addr_join.sv
module cart_addr_join
    import cart_bank_pkg::*;
#(
    parameter int BW = 4,
    localparam int OW = BW + OFFSET_W
) (
    input  logic [BW-1:0]       bank,
    input  logic [OFFSET_W-1:0] offset,
    output logic [OW-1:0]       ext_addr
);
    assign ext_addr = {bank, offset};
endmodule

// File: rtl/cart_halfbank_switch.sv
module cart_halfbank_switch
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 8,
    localparam int ROM_AW = ROM_BANK_W + OFFSET_W,
    localparam int RAM_AW = RAM_BANK_W + OFFSET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [15:0]       addr,
    input  logic [7:0]        wdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_ce,
    output logic              ram_we
);
    access_t               acc;
    logic [ROM_BANK_W-1:0] rom_bank_q;
    logic [RAM_BANK_W-1:0] ram_bank_q;

    cart_addr_decode u_dec (
        .cs   (cs),
        .we   (we),
        .addr (addr),
        .acc  (acc)
    );

    cart_bank_reg #(.W(ROM_BANK_W)) u_rom_bank (
        .clk  (clk),
        .rst  (rst),
        .load (acc.rom_load),
        .d    (addr[ROM_BANK_W:1]),
        .q    (rom_bank_q)
    );

    cart_bank_reg #(.W(RAM_BANK_W)) u_ram_bank (
        .clk  (clk),
        .rst  (rst),
        .load (acc.ram_load),
        .d    (wdata[RAM_BANK_W-1:0]),
        .q    (ram_bank_q)
    );

    cart_addr_join #(.BW(ROM_BANK_W)) u_rom_join (
        .bank     (rom_bank_q),
        .offset   (addr[OFFSET_W-1:0]),
        .ext_addr (rom_addr)
    );

    cart_addr_join #(.BW(RAM_BANK_W)) u_ram_join (
        .bank     (ram_bank_q),
        .offset   (addr[OFFSET_W-1:0]),
        .ext_addr (ram_addr)
    );

    assign rom_ce = acc.rom_ce;
    assign ram_ce = acc.ram_ce;
    assign ram_we = acc.ram_we;
endmodule

// File: rtl/cart_halfbank_checker.sv
module cart_halfbank_checker #(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cs,
    input logic                  we,
    input logic [15:0]           addr,
    input logic [7:0]            wdata,
    input logic                  rom_ce,
    input logic                  ram_ce,
    input logic                  ram_we,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [RAM_BANK_W-1:0] ram_bank
);
    // R1: ROM enable only on selected reads of the lower half
    a_r1_rom_ce_scope: assert property (@(posedge clk) disable iff (rst)
        rom_ce |-> (cs && !we && addr[15:12] == 4'h6));

    // R2: RAM enable only inside the upper half
    a_r2_ram_ce_scope: assert property (@(posedge clk) disable iff (rst)
        (ram_ce || ram_we) |-> (cs && addr[15:12] == 4'h7));

    // R3: ROM trigger loads the page from the address
    a_r3_rom_load: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[15:8] == 8'h60) |=> (rom_bank == $past(addr[ROM_BANK_W:1])));

    // R4: RAM trigger loads the page from the data
    a_r4_ram_load: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[15:8] == 8'h68) |=> (ram_bank == $past(wdata[RAM_BANK_W-1:0])));

    // R6: RAM-half writes keep both pages
    a_r6_ram_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (cs && we && addr[15:12] == 4'h7) |=> ($stable(rom_bank) && $stable(ram_bank)));

    // R8: no enables without select
    a_r8_no_cs: assert property (@(posedge clk) disable iff (rst)
        !cs |-> (!rom_ce && !ram_ce && !ram_we));

    // R9: reset clears both pages
    a_r9_reset: assert property (@(posedge clk)
        rst |=> (rom_bank == '0 && ram_bank == '0));
endmodule

bind cart_halfbank_switch cart_halfbank_checker #(
    .ROM_BANK_W(ROM_BANK_W),
    .RAM_BANK_W(RAM_BANK_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .rom_ce   (rom_ce),
    .ram_ce   (ram_ce),
    .ram_we   (ram_we),
    .rom_bank (rom_bank_q),
    .ram_bank (ram_bank_q)
);

// File: tb/tb_cart_halfbank_switch.sv
module tb_cart_halfbank_switch;
    localparam int RB = 7;
    localparam int MB = 8;
    localparam int RAW = RB + 12;
    localparam int MAW = MB + 12;

    logic clk = 0;
    logic rst, cs, we;
    logic [15:0] addr;
    logic [7:0] wdata;
    logic [RAW-1:0] rom_addr;
    logic [MAW-1:0] ram_addr;
    logic rom_ce, ram_ce, ram_we;

    int checks = 0, fails = 0;
    int m_rom = 0, m_ram = 0;
    byte dut_mem[int];
    byte ref_mem[int];
    bit done = 0;

    always #2.5 clk = ~clk;

    cart_halfbank_switch dut (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
        .rom_addr(rom_addr), .rom_ce(rom_ce), .ram_addr(ram_addr),
        .ram_ce(ram_ce), .ram_we(ram_we)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cs = 0; we = 0; addr = 0; wdata = 0;
        @(posedge clk);
        m_rom = 0; m_ram = 0;
        dut_mem.delete(); ref_mem.delete();
        @(negedge clk);
        rst = 0;
    endtask

    // one access: drive, compare every output with the model, then advance the model
    task automatic cyc(input bit c, input bit w, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
        bit rh, mh;
        int e_rom_addr, e_ram_addr;
        @(negedge clk);
        cs = c; we = w; addr = a; wdata = d;
        #1;
        rh = (a[15:12] == 4'h6);
        mh = (a[15:12] == 4'h7);
        e_rom_addr = (m_rom << 12) | int'(a[11:0]);
        e_ram_addr = (m_ram << 12) | int'(a[11:0]);
        chk(rom_addr == RAW'(e_rom_addr), tag, "rom_addr", int'(rom_addr), e_rom_addr);
        chk(ram_addr == MAW'(e_ram_addr), tag, "ram_addr", int'(ram_addr), e_ram_addr);
        chk(rom_ce == (c && !w && rh), tag, "rom_ce", int'(rom_ce), int'(c && !w && rh));
        chk(ram_ce == (c && mh), tag, "ram_ce", int'(ram_ce), int'(c && mh));
        chk(ram_we == (c && w && mh), tag, "ram_we", int'(ram_we), int'(c && w && mh));
        if (c && !w && mh) begin
            byte got, exp;
            got = dut_mem.exists(int'(ram_addr)) ? dut_mem[int'(ram_addr)] : 8'h00;
            exp = ref_mem.exists(e_ram_addr) ? ref_mem[e_ram_addr] : 8'h00;
            chk(got == exp, tag, "ram read data", int'(got), int'(exp));
        end
        @(posedge clk);
        if (ram_we) dut_mem[int'(ram_addr)] = d;
        if (c && w && mh) ref_mem[e_ram_addr] = d;
        if (c && w && a[15:8] == 8'h60) m_rom = int'(a[7:1]);
        if (c && w && a[15:8] == 8'h68) m_ram = int'(d);
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        cyc(1, 0, 16'h6123, 8'h00, "R9");       // reset ROM page 0
        cyc(1, 0, 16'h7456, 8'h00, "R9");       // reset RAM page 0
        cyc(1, 1, 16'h600B, 8'h00, "R3");       // page 5, A0 set
        cyc(1, 0, 16'h6ABC, 8'h00, "R3");
        cyc(1, 1, 16'h68F3, 8'h1A, "R4");       // low addr bits nonzero
        cyc(1, 0, 16'h7010, 8'h00, "R4");
        cyc(1, 0, 16'h6010, 8'h00, "R5");       // ROM page still 5
        cyc(1, 1, 16'h6004, 8'h99, "R5");       // ROM page 2, RAM stays 1A
        cyc(1, 0, 16'h7010, 8'h00, "R5");
        cyc(1, 1, 16'h7777, 8'h55, "R6");
        cyc(1, 1, 16'h7001, 8'h22, "R6");
        cyc(1, 0, 16'h7777, 8'h00, "R6");       // reads 55, pages unchanged
        cyc(1, 1, 16'h6100, 8'h07, "R7");
        cyc(1, 1, 16'h67FE, 8'h07, "R7");
        cyc(1, 1, 16'h6900, 8'h07, "R7");
        cyc(1, 1, 16'h5000, 8'h07, "R7");
        cyc(1, 1, 16'h8000, 8'h07, "R7");
        cyc(1, 0, 16'h7001, 8'h00, "R7");
        cyc(0, 1, 16'h6002, 8'h03, "R8");
        cyc(0, 1, 16'h6800, 8'h03, "R8");
        cyc(0, 0, 16'h6002, 8'h00, "R8");
        cyc(0, 1, 16'h7002, 8'h03, "R8");
        cyc(1, 0, 16'h7002, 8'h00, "R8");
        cyc(1, 1, 16'h60FE, 8'h00, "R3");       // top ROM page 127
        cyc(1, 0, 16'h6FFF, 8'h00, "R1");
        cyc(1, 1, 16'h6800, 8'hFF, "R4");       // top RAM page
        cyc(1, 1, 16'h7FFF, 8'hA5, "R2");
        cyc(1, 0, 16'h7FFF, 8'h00, "R2");
        cyc(1, 1, 16'h6FFF, 8'h00, "R1");       // ROM-half write: no rom_ce
        do_reset();
        cyc(1, 0, 16'h6800, 8'h00, "R9");
        cyc(1, 0, 16'h7FFF, 8'h00, "R9");
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0: a = {8'h60, lfsr[15:8]};
                3'd1: a = {8'h68, lfsr[15:8]};
                3'd2, 3'd3: a = {4'h7, 4'h0, lfsr[15:8]};
                3'd4: a = {4'h6, lfsr[11:0]};
                default: a = {lfsr[15:8], lfsr[7:0]};
            endcase
            cyc(lfsr[3] | lfsr[4], lfsr[5], a, lfsr[15:8] ^ 8'h3C, "R2");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule